// File: doc/BRIEF.md
# Secured Configuration Store Controller

This block keeps the configuration image of a small programmable logic device: the product-term connection bits, the per-output architecture bits, a 64-bit signature word and a lock flag. A host drives it through a one-command-per-cycle port: it can sweep-erase the whole image, OR data into a word, read a word back, lock the part, program the signature or read the signature. A second, always-open read port hands the stored configuration words to the logic core, which must keep working whether or not the part is locked.

Storage is organised as 32-bit words. Program operations can only turn bits on. Only the erase sweep turns them off, and it walks the image one word per cycle. Once the lock is set, every command that would read or alter the image is refused until an erase has completed. The erase clears the lock as its final step. Reset loads the blank, unlocked image.

Top module: `cfgmem_ctrl`

## Requirements
- R1: After reset, busy, rsp_valid and secure are 0, and every configuration word reads as 0 on the core port.
- R2: Op code 2 (program word) with an address below 65 ORs cmd_wdata into that word. Bits that were already set stay set. rsp_valid is 1 with rsp_err 0 in the cycle after acceptance.
- R3: Op code 3 (read word) with an address below 65 returns that word on rsp_rdata with rsp_err 0 in the cycle after acceptance.
- R4: Op code 1 (erase) holds busy high for exactly 67 cycles after acceptance. In that time it clears every word: array words 0..63, architecture word 64 and both signature words. It then gives one rsp_valid with rsp_err 0 and rsp_rdata 0, and secure is 0 from that point.
- R5: A command presented while busy is 1 is ignored. It gets no response and changes no word.
- R6: Op code 4 (lock) is always accepted without error and sets secure. Only a completed erase returns secure to 0.
- R7: While secure is 1, op codes 2, 3, 5, 6 and 7 are refused. They respond with rsp_err 1 and rsp_rdata 0 and change no word.
- R8: Op code 7 (program and lock) programs the addressed word as in R2 and sets secure in the same cycle.
- R9: Op codes 5 (program signature) and 6 (read signature) use address 0 or 1 to select the signature half. Programming ORs the data in, and reading returns the half.
- R10: Op code 0 and any address out of range for its op (65 or more for word ops, 2 or more for signature ops) respond with rsp_err 1 and change nothing.
- R11: core_rdata shows the word at core_addr combinationally for addresses below 65, and 0 otherwise. This holds whether or not the part is locked, and a word programmed at a clock edge appears there after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset to the blank image |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | 7 | Word or signature-half address |
| cmd_wdata | input | 32 | Data to OR into the target |
| busy | output | 1 | Erase sweep running; commands ignored |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Command refused or invalid |
| rsp_rdata | output | 32 | Read result, 0 on error |
| secure | output | 1 | Lock flag |
| core_addr | input | 7 | Core-side configuration word address |
| core_rdata | output | 32 | Core-side configuration word |

## Verification
Two functions can land in the same clock edge. The first case is the final step of the erase sweep and a program command that the host has held on the port for the whole sweep. The bench keeps cmd_valid high from the start of the erase until one cycle after busy drops. The sweep's completion response must come first. The held command must be ignored while busy and then accepted in the following cycle, so it lands on the freshly blank image. The second case is the core read port pointed at a word in the same cycle the host programs it: the old value must hold until the edge and the new value must appear after it. A behavioural model predicts every output on every cycle, and any difference is reported.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;

  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_ERASE    = 3'd1,
    OP_PROG     = 3'd2,
    OP_READ     = 3'd3,
    OP_LOCK     = 3'd4,
    OP_SIGPROG  = 3'd5,
    OP_SIGREAD  = 3'd6,
    OP_PROGLOCK = 3'd7
  } cmd_op_e;

  // address fits below the limit of its region
  function automatic logic fits_below(input int unsigned a, input int unsigned limit);
    return a < limit;
  endfunction

  // signature halves live after the configuration words
  function automatic int unsigned sig_slot(input int unsigned a, input int unsigned base);
    return base + a;
  endfunction

  // ops that the lock forbids
  function automatic logic lock_blocks(input cmd_op_e op);
    return (op == OP_PROG) || (op == OP_READ) || (op == OP_SIGPROG) ||
           (op == OP_SIGREAD) || (op == OP_PROGLOCK);
  endfunction

endpackage

// File: rtl/cfgmem_guard.sv
module cfgmem_guard
  import cfgmem_pkg::*;
#(
  parameter int CFG_WORDS = 65,
  parameter int SIG_WORDS = 2,
  parameter int AW        = 7
) (
  input  cmd_op_e         op,
  input  logic [AW-1:0]   addr,
  input  logic            locked,
  output logic            ok,
  output logic            wr,
  output logic            rd,
  output logic            set_lock,
  output logic            erase,
  output logic [AW-1:0]   idx
);

  logic cfg_hit, sig_hit;
  assign cfg_hit = fits_below(int'(addr), CFG_WORDS);
  assign sig_hit = fits_below(int'(addr), SIG_WORDS);

  always_comb begin
    ok = 1'b0; wr = 1'b0; rd = 1'b0; set_lock = 1'b0; erase = 1'b0; idx = '0;
    unique case (op)
      OP_ERASE: begin ok = 1'b1; erase = 1'b1; end
      OP_LOCK:  begin ok = 1'b1; set_lock = 1'b1; end
      OP_PROG, OP_PROGLOCK: if (cfg_hit) begin
        ok = 1'b1; wr = 1'b1; idx = addr; set_lock = (op == OP_PROGLOCK);
      end
      OP_READ: if (cfg_hit) begin ok = 1'b1; rd = 1'b1; idx = addr; end
      OP_SIGPROG: if (sig_hit) begin
        ok = 1'b1; wr = 1'b1; idx = AW'(sig_slot(int'(addr), CFG_WORDS));
      end
      OP_SIGREAD: if (sig_hit) begin
        ok = 1'b1; rd = 1'b1; idx = AW'(sig_slot(int'(addr), CFG_WORDS));
      end
      default: ;
    endcase
    if (locked && lock_blocks(op)) begin
      ok = 1'b0; wr = 1'b0; rd = 1'b0; set_lock = 1'b0; idx = '0;
    end
  end

endmodule

// File: rtl/cfgmem_sweep.sv
module cfgmem_sweep #(
  parameter int TOTAL = 67,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          active,
  output logic [AW-1:0] idx,
  output logic          last
);

  localparam logic [AW-1:0] LAST_IDX = AW'(TOTAL - 1);

  assign last = active && (idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (active) begin
      active <= !last;
      idx    <= last ? '0 : idx + 1'b1;
    end else if (start) begin
      active <= 1'b1;
      idx    <= '0;
    end
  end

  a_r4_sweep_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> idx == '0);
  a_r4_sweep_stops: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !active);
  a_r4_sweep_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> idx <= LAST_IDX);

endmodule

// File: rtl/cfgmem_store.sv
module cfgmem_store #(
  parameter int TOTAL     = 67,
  parameter int CFG_WORDS = 65,
  parameter int DW        = 32,
  parameter int AW        = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          clr_en,
  input  logic [AW-1:0] clr_idx,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  input  logic [AW-1:0] core_idx,
  output logic [DW-1:0] core_data
);

  logic [DW-1:0] words [TOTAL];

  for (genvar w = 0; w < TOTAL; w++) begin : g_word
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                q <= '0;
      else if (clr_en && clr_idx == AW'(w))      q <= '0;
      else if (wr_en && wr_idx == AW'(w))        q <= q | wr_data;
    end
    assign words[w] = q;
  end

  assign rd_data   = words[rd_idx];
  assign core_data = (int'(core_idx) < CFG_WORDS) ? words[core_idx] : '0;

  a_r2_new_bits_set: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !clr_en |=> (words[$past(wr_idx)] & $past(wr_data)) == $past(wr_data));
  a_r2_old_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !clr_en |=> (words[$past(wr_idx)] & $past(words[wr_idx])) == $past(words[wr_idx]));
  a_r4_word_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> words[$past(clr_idx)] == '0);

endmodule

// File: rtl/cfgmem_ctrl.sv
module cfgmem_ctrl
  import cfgmem_pkg::*;
#(
  parameter int ARRAY_WORDS = 64,
  parameter int ARCH_WORDS  = 1,
  parameter int SIG_BITS    = 64,
  parameter int DW          = 32,
  localparam int CFG_WORDS  = ARRAY_WORDS + ARCH_WORDS,
  localparam int SIG_WORDS  = SIG_BITS / DW,
  localparam int TOTAL      = CFG_WORDS + SIG_WORDS,
  localparam int AW         = $clog2(TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          busy,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata,
  output logic          secure,
  input  logic [AW-1:0] core_addr,
  output logic [DW-1:0] core_rdata
);

  cmd_op_e       op;
  logic          accept;
  logic          g_ok, g_wr, g_rd, g_lock, g_erase;
  logic [AW-1:0] g_idx;
  logic          sw_active, sw_last;
  logic [AW-1:0] sw_idx;
  logic          store_wr;
  logic [DW-1:0] rd_word;

  assign op       = cmd_op_e'(cmd_op);
  assign accept   = cmd_valid && !sw_active;
  assign store_wr = accept && g_wr;
  assign busy     = sw_active;

  cfgmem_guard #(.CFG_WORDS(CFG_WORDS), .SIG_WORDS(SIG_WORDS), .AW(AW)) u_guard (
    .op(op), .addr(cmd_addr), .locked(secure),
    .ok(g_ok), .wr(g_wr), .rd(g_rd), .set_lock(g_lock), .erase(g_erase), .idx(g_idx)
  );

  cfgmem_sweep #(.TOTAL(TOTAL), .AW(AW)) u_sweep (
    .clk(clk), .rst_n(rst_n), .start(accept && g_erase),
    .active(sw_active), .idx(sw_idx), .last(sw_last)
  );

  cfgmem_store #(.TOTAL(TOTAL), .CFG_WORDS(CFG_WORDS), .DW(DW), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(store_wr), .wr_idx(g_idx), .wr_data(cmd_wdata),
    .clr_en(sw_active), .clr_idx(sw_idx),
    .rd_idx(g_idx), .rd_data(rd_word),
    .core_idx(core_addr), .core_data(core_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (sw_last) begin
        rsp_valid <= 1'b1;
        rsp_err   <= 1'b0;
        rsp_rdata <= '0;
      end else if (accept && !g_erase) begin
        rsp_valid <= 1'b1;
        rsp_err   <= !g_ok;
        rsp_rdata <= g_rd ? rd_word : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   secure <= 1'b0;
    else if (sw_last)             secure <= 1'b0;
    else if (accept && g_lock)    secure <= 1'b1;
  end

  a_r5_silent_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !sw_last |=> !rsp_valid);
  a_r5_no_write_in_sweep: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_wr && sw_active));
  a_r4_erase_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    sw_last |=> !secure && rsp_valid && !rsp_err);
  a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    secure && !sw_last |=> secure);
  a_r6_lock_cmd_sets: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy && cmd_op == 3'd4 |=> secure && rsp_valid && !rsp_err);
  a_r7_locked_refused: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy && secure && lock_blocks(op) |=> rsp_valid && rsp_err);
  a_r7_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_rdata == '0);
  a_r10_null_op_err: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy && cmd_op == 3'd0 |=> rsp_valid && rsp_err);

endmodule

// File: tb/sim_cfgmem_ctrl.sv
module sim_cfgmem_ctrl;

  localparam int CFGW = 65;
  localparam int SIGW = 2;
  localparam int TOT  = 67;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [6:0]  cmd_addr = 7'd0;
  logic [31:0] cmd_wdata = 32'd0;
  logic [6:0]  core_addr = 7'd0;
  logic        busy, rsp_valid, rsp_err, secure;
  logic [31:0] rsp_rdata, core_rdata;

  always #4 clk = ~clk;

  cfgmem_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .secure(secure), .core_addr(core_addr), .core_rdata(core_rdata)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  string tag    = "R1";

  // behavioural reference
  logic [31:0] m_mem [TOT];
  bit          m_busy, m_sec, m_rv, m_err;
  int          m_cnt;
  logic [31:0] m_rd;

  always @(posedge clk) begin : model
    int a;
    a = int'(cmd_addr);
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 32'd0;
      m_busy = 0; m_sec = 0; m_rv = 0; m_err = 0; m_cnt = 0; m_rd = 32'd0;
    end else begin
      m_rv = 0;
      if (m_busy) begin
        m_mem[m_cnt] = 32'd0;
        if (m_cnt == TOT - 1) begin
          m_busy = 0; m_sec = 0; m_rv = 1; m_err = 0; m_rd = 32'd0;
        end else m_cnt++;
      end else if (cmd_valid) begin
        m_rv = 1; m_err = 1; m_rd = 32'd0;
        case (cmd_op)
          3'd1: begin m_busy = 1; m_cnt = 0; m_rv = 0; end
          3'd4: begin m_sec = 1; m_err = 0; end
          3'd2, 3'd7: if (!m_sec && a < CFGW) begin
            m_mem[a] = m_mem[a] | cmd_wdata; m_err = 0;
            if (cmd_op == 3'd7) m_sec = 1;
          end
          3'd3: if (!m_sec && a < CFGW) begin m_rd = m_mem[a]; m_err = 0; end
          3'd5: if (!m_sec && a < SIGW) begin
            m_mem[CFGW + a] = m_mem[CFGW + a] | cmd_wdata; m_err = 0;
          end
          3'd6: if (!m_sec && a < SIGW) begin m_rd = m_mem[CFGW + a]; m_err = 0; end
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] core_expect(input logic [6:0] ca);
    return (int'(ca) < CFGW) ? m_mem[ca] : 32'd0;
  endfunction

  // compare every cycle, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      checks++;
      if (busy !== m_busy || rsp_valid !== m_rv || secure !== m_sec ||
          core_rdata !== core_expect(core_addr) ||
          (m_rv && (rsp_err !== m_err || rsp_rdata !== m_rd))) begin
        fails++;
        $display("FAIL %s: act busy=%0b rv=%0b err=%0b rd=%h sec=%0b core=%h | exp busy=%0b rv=%0b err=%0b rd=%h sec=%0b core=%h",
                 tag, busy, rsp_valid, rsp_err, rsp_rdata, secure, core_rdata,
                 m_busy, m_rv, m_err, m_rd, m_sec, core_expect(core_addr));
      end
    end
  end

  task automatic expect_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic [6:0] a, input logic [31:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    int n;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    tag = "R1";
    expect_eq("R1", {29'd0, busy, rsp_valid, secure}, 32'd0);
    for (int i = 0; i < CFGW; i += 16) begin core_addr = 7'(i); idle(1); end

    tag = "R2";
    core_addr = 7'd3;
    send(3'd2, 7'd3, 32'h0000_00F0);        // core port sees update after edge (R11)
    expect_eq("R11", core_rdata, 32'h0000_00F0);
    send(3'd2, 7'd3, 32'h0F00_0030);
    send(3'd2, 7'd64, 32'h0003_FFFF);
    tag = "R3";
    send(3'd3, 7'd3, 32'd0);
    expect_eq("R3", rsp_rdata, 32'h0F00_00F0);
    send(3'd3, 7'd64, 32'd0);
    send(3'd3, 7'd5, 32'd0);

    tag = "R9";
    send(3'd5, 7'd0, 32'hDEAD_0001);
    send(3'd5, 7'd1, 32'h1234_5678);
    send(3'd5, 7'd1, 32'h8000_0000);
    send(3'd6, 7'd1, 32'd0);
    expect_eq("R9", rsp_rdata, 32'h9234_5678);
    send(3'd6, 7'd0, 32'd0);

    tag = "R10";
    send(3'd0, 7'd3, 32'hFFFF_FFFF);
    send(3'd2, 7'd65, 32'hFFFF_FFFF);
    send(3'd5, 7'd2, 32'hFFFF_FFFF);
    send(3'd6, 7'd2, 32'd0);
    expect_eq("R10", {31'd0, rsp_err}, 32'd1);

    tag = "R11";
    core_addr = 7'd66; idle(1);
    core_addr = 7'd100; idle(1);
    core_addr = 7'd64; idle(1);

    tag = "R6";
    send(3'd4, 7'd0, 32'd0);
    expect_eq("R6", {31'd0, secure}, 32'd1);
    send(3'd4, 7'd0, 32'd0);

    tag = "R7";
    send(3'd3, 7'd3, 32'd0);
    expect_eq("R7", {31'd0, rsp_err}, 32'd1);
    send(3'd2, 7'd5, 32'hFFFF_FFFF);
    send(3'd6, 7'd0, 32'd0);
    send(3'd5, 7'd0, 32'hFFFF_FFFF);
    send(3'd7, 7'd6, 32'hFFFF_FFFF);
    tag = "R11";
    core_addr = 7'd3; idle(1);
    expect_eq("R11", core_rdata, 32'h0F00_00F0);

    tag = "R4";
    send(3'd1, 7'd0, 32'd0);
    // hold a program across the sweep and one cycle beyond (R5)
    cmd_valid = 1'b1; cmd_op = 3'd2; cmd_addr = 7'd4; cmd_wdata = 32'h0000_AAAA;
    n = 0;
    while (busy && n < 200) begin n++; @(negedge clk); end
    expect_eq("R4", n, TOT);
    expect_eq("R4", {30'd0, rsp_valid, secure}, 32'd2);
    @(negedge clk);
    cmd_valid = 1'b0;
    tag = "R5";
    send(3'd3, 7'd4, 32'd0);
    expect_eq("R5", rsp_rdata, 32'h0000_AAAA);
    tag = "R4";
    send(3'd3, 7'd3, 32'd0);
    expect_eq("R4", rsp_rdata, 32'd0);
    send(3'd3, 7'd64, 32'd0);
    send(3'd6, 7'd1, 32'd0);
    expect_eq("R4", rsp_rdata, 32'd0);

    tag = "R8";
    send(3'd7, 7'd10, 32'h5A5A_0000);
    expect_eq("R8", {31'd0, secure}, 32'd1);
    send(3'd3, 7'd10, 32'd0);
    core_addr = 7'd10; idle(1);
    expect_eq("R8", core_rdata, 32'h5A5A_0000);
    send(3'd1, 7'd0, 32'd0);
    idle(TOT + 2);
    expect_eq("R8", {31'd0, secure}, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule